// File: doc/BRIEF.md
# Type A Card Response Frame Encoder

This block turns a card-side response frame into the load-modulation bit that a Type A contactless card drives back to a reader. The block runs on the 13.56 MHz carrier clock. The modulation uses a subcarrier at one sixteenth of the carrier. A frame is one of two kinds:
- a short frame of 1 to 7 bits, taken from the first byte;
- one or more whole bytes, each byte followed by an odd-parity bit that the caller has already computed.

The caller places the payload bytes, the packed parity bits and a bit count on the inputs, then pulses `start`. The block copies all three into its own registers on that clock edge. It then plays out the frame in fixed-length bit slots:
- one silent lead-in slot;
- the start-of-frame slot;
- the payload slots;
- the closing silent slot.

`busy` is high for the whole frame, and `done` pulses once when the frame ends. The block does not generate the carrier, demodulate the reader and compute parity or CRC.

Top module: `nfa_resp_encoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done` and `mod_out` are all 0.
- R2: A `start` pulse while `busy` is low copies `frame_data`, `parity_bits` and `bit_count`. `busy` is 1 from the next cycle. It stays 1 for exactly 128 × (number of slots) cycles.
- R3: Each slot lasts 128 clocks, split into 16 phases of 8 clocks. A first-half slot modulates phases 0–7, and a second-half slot modulates phases 8–15. Within a modulated half, the level is 1 on even phases and 0 on odd phases. A silent slot is 0 throughout. No high run on `mod_out` exceeds 8 cycles.
- R4: Every frame is sent in this slot order:
  - one silent slot;
  - a first-half slot (start of frame);
  - the payload;
  - one silent slot (end of frame).
- R5: When `bit_count` ≥ 8, the payload holds floor(`bit_count`/8) bytes. Byte i is `frame_data[8i+7:8i]`, and its bits are sent LSB first. Each byte is followed by its parity slot. A 1 is sent as a first-half slot and a 0 as a second-half slot. Leftover bits beyond a whole byte are not sent.
- R6: The parity bit of byte i is `parity_bits[8*(i/8) + 7 - (i%8)]`. The bit for the first byte of each group of eight is the MSB of its parity byte.
- R7: When `bit_count` < 8, the payload is bits 0 to `bit_count`-1 of `frame_data`, LSB first, with no parity slot. A count of 0 sends only the lead-in, start-of-frame and end-of-frame slots.
- R8: `mod_out` is registered and follows the slot waveform one clock late. It is 0 whenever `busy` was low in the previous cycle.
- R9: `done` is high for exactly one cycle: the first cycle in which `busy` is low after a frame.
- R10: A `start` pulse or an input change while `busy` is high has no effect on the frame being sent, and does not start a new frame.
- R11: A `bit_count` above 8 × MAX_BYTES sends MAX_BYTES bytes, each with its parity slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a frame |
| frame_data | input | 8×MAX_BYTES | Payload bytes, byte i at bits 8i+7:8i |
| parity_bits | input | 8×ceil(MAX_BYTES/8) | Packed parity, first byte of each group of eight at the MSB |
| bit_count | input | CNT_W | Number of payload bits |
| mod_out | output | 1 | Load-modulation level |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions take three things about the inputs for granted:
- `start` is a one-cycle pulse that may come at any time, including during a frame;
- `bit_count` may hold any value of its width;
- `rst` is held for at least one clock before the first frame.

The bench keeps to these conditions:
- it drives inputs only on falling edges;
- it holds `start` for one cycle;
- it issues a stray `start`, with altered payload and count, in the middle of a frame.

Its counts cover 0, 1 and 7 bits, a count with leftover bits, and a count far above the buffer size. Expected `mod_out`, `busy` and `done` values come from a slot-list model that is compared on every clock.

// File: rtl/nfa_enc_pkg.sv
package nfa_enc_pkg;

    // Carrier clocks per subcarrier half-period, and half-periods per bit slot.
    localparam int unsigned SUB_PHASE_CLKS = 8;
    localparam int unsigned SLOT_PHASES    = 16;
    localparam int unsigned SLOT_CLKS      = SUB_PHASE_CLKS * SLOT_PHASES;
    localparam int unsigned SUBCNT_W       = $clog2(SUB_PHASE_CLKS);
    localparam int unsigned PHASE_W        = $clog2(SLOT_PHASES);

    // Slot waveforms: silent, modulated in first half, modulated in second half.
    typedef enum logic [1:0] {
        SYM_SILENT      = 2'd0,
        SYM_FIRST_HALF  = 2'd1,
        SYM_SECOND_HALF = 2'd2
    } sym_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_SOF  = 3'd2,
        ST_DATA = 3'd3,
        ST_PAR  = 3'd4,
        ST_EOF  = 3'd5
    } fsm_e;

    // Position inside the current slot.
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               last_clk;
    } slot_pos_t;

    // Logic value to slot waveform.
    function automatic sym_e bit_sym(input logic b);
        return b ? SYM_FIRST_HALF : SYM_SECOND_HALF;
    endfunction

    // Level of a slot waveform at a given phase. The MSB of the phase marks
    // the second half, and the LSB marks an odd half-period.
    function automatic logic sym_level(input sym_e s, input logic [PHASE_W-1:0] ph);
        logic upper;
        logic odd;
        upper = ph[PHASE_W-1];
        odd   = ph[0];
        case (s)
            SYM_FIRST_HALF:  return !upper && !odd;
            SYM_SECOND_HALF: return  upper && !odd;
            default:         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/nfa_slot_timer.sv
module nfa_slot_timer
    import nfa_enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output slot_pos_t pos
);

    localparam logic [SUBCNT_W-1:0] SUB_LAST   = SUBCNT_W'(SUB_PHASE_CLKS - 1);
    localparam logic [PHASE_W-1:0]  PHASE_LAST = PHASE_W'(SLOT_PHASES - 1);

    logic [SUBCNT_W-1:0] sub_q;
    logic [PHASE_W-1:0]  ph_q;
    logic                sub_end;

    assign sub_end = (sub_q == SUB_LAST);

    // Both counters are held at zero while idle, so the first busy cycle is
    // clock 0 of phase 0.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sub_q <= '0;
            ph_q  <= '0;
        end else if (sub_end) begin
            sub_q <= '0;
            ph_q  <= (ph_q == PHASE_LAST) ? '0 : ph_q + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    assign pos.phase    = ph_q;
    assign pos.last_clk = run && sub_end && (ph_q == PHASE_LAST);

endmodule

// File: rtl/nfa_frame_sequencer.sv
module nfa_frame_sequencer
    import nfa_enc_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 10,
    parameter int unsigned CNT_W     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  start,
    input  logic [MAX_BYTES*8-1:0]                frame_data,
    input  logic [((MAX_BYTES+7)/8)*8-1:0]        parity_bits,
    input  logic [CNT_W-1:0]                      bit_count,
    input  logic                                  slot_end,
    output sym_e                                  sym,
    output logic                                  busy,
    output logic                                  done
);

    localparam int unsigned DATA_W = MAX_BYTES * 8;
    localparam int unsigned PAR_W  = ((MAX_BYTES + 7) / 8) * 8;
    localparam int unsigned BIDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    fsm_e                st_q;
    logic [DATA_W-1:0]   data_q;
    logic [PAR_W-1:0]    par_q;
    logic                short_q;
    logic                empty_q;
    logic [2:0]          last_bit_q;
    logic [BIDX_W-1:0]   last_byte_q;
    logic [2:0]          bit_idx_q;
    logic [BIDX_W-1:0]   byte_idx_q;

    // Frame description derived from the requested bit count.
    logic [CNT_W-1:0]    n_bytes_c;
    logic [BIDX_W-1:0]   last_byte_c;
    logic                short_c;
    logic                empty_c;
    logic [2:0]          last_bit_c;

    always_comb begin
        n_bytes_c = bit_count >> 3;
        if (n_bytes_c > CNT_W'(MAX_BYTES)) begin
            n_bytes_c = CNT_W'(MAX_BYTES);
        end
        short_c     = (n_bytes_c == '0);
        empty_c     = (bit_count == '0);
        last_bit_c  = bit_count[2:0] - 3'd1;
        last_byte_c = BIDX_W'(n_bytes_c - 1'b1);
    end

    // Current payload bit and parity bit.
    logic data_bit;
    logic par_bit;

    assign data_bit = data_q[{byte_idx_q, bit_idx_q}];

    // Parity is packed eight per byte, first byte of a group at the MSB:
    // the low three index bits are inverted, the upper bits pick the byte.
    generate
        if (BIDX_W > 3) begin : g_par_multi
            assign par_bit = par_q[{byte_idx_q[BIDX_W-1:3], ~byte_idx_q[2:0]}];
        end else begin : g_par_single
            logic [2:0] par_idx;
            assign par_idx = ~3'(byte_idx_q);
            assign par_bit = par_q[par_idx];
        end
    endgenerate

    logic payload_last_bit;
    assign payload_last_bit = short_q ? (bit_idx_q == last_bit_q) : (bit_idx_q == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            done        <= 1'b0;
            data_q      <= '0;
            par_q       <= '0;
            short_q     <= 1'b0;
            empty_q     <= 1'b0;
            last_bit_q  <= '0;
            last_byte_q <= '0;
            bit_idx_q   <= '0;
            byte_idx_q  <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        data_q      <= frame_data;
                        par_q       <= parity_bits;
                        short_q     <= short_c;
                        empty_q     <= empty_c;
                        last_bit_q  <= last_bit_c;
                        last_byte_q <= last_byte_c;
                        bit_idx_q   <= '0;
                        byte_idx_q  <= '0;
                        st_q        <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (slot_end) st_q <= ST_SOF;
                end
                ST_SOF: begin
                    if (slot_end) st_q <= empty_q ? ST_EOF : ST_DATA;
                end
                ST_DATA: begin
                    if (slot_end) begin
                        if (payload_last_bit) begin
                            bit_idx_q <= '0;
                            st_q      <= short_q ? ST_EOF : ST_PAR;
                        end else begin
                            bit_idx_q <= bit_idx_q + 3'd1;
                        end
                    end
                end
                ST_PAR: begin
                    if (slot_end) begin
                        if (byte_idx_q == last_byte_q) begin
                            st_q <= ST_EOF;
                        end else begin
                            byte_idx_q <= byte_idx_q + 1'b1;
                            st_q       <= ST_DATA;
                        end
                    end
                end
                ST_EOF: begin
                    if (slot_end) begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st_q != ST_IDLE);

    always_comb begin
        case (st_q)
            ST_SOF:  sym = SYM_FIRST_HALF;
            ST_DATA: sym = bit_sym(data_bit);
            ST_PAR:  sym = bit_sym(par_bit);
            default: sym = SYM_SILENT;
        endcase
    end

endmodule

// File: rtl/nfa_slot_modulator.sv
module nfa_slot_modulator
    import nfa_enc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  sym_e               sym,
    input  logic [PHASE_W-1:0] phase,
    output logic               mod_out
);

    // Registered so the pin carries no decode glitches.
    always_ff @(posedge clk) begin
        if (rst) begin
            mod_out <= 1'b0;
        end else begin
            mod_out <= active && sym_level(sym, phase);
        end
    end

endmodule

// File: rtl/nfa_resp_encoder.sv
module nfa_resp_encoder
    import nfa_enc_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 10,
    parameter int unsigned CNT_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic [MAX_BYTES*8-1:0]         frame_data,
    input  logic [((MAX_BYTES+7)/8)*8-1:0] parity_bits,
    input  logic [CNT_W-1:0]               bit_count,
    output logic                           mod_out,
    output logic                           busy,
    output logic                           done
);

    slot_pos_t pos;
    sym_e      sym;

    nfa_slot_timer timer_i (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .pos (pos)
    );

    nfa_frame_sequencer #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .frame_data  (frame_data),
        .parity_bits (parity_bits),
        .bit_count   (bit_count),
        .slot_end    (pos.last_clk),
        .sym         (sym),
        .busy        (busy),
        .done        (done)
    );

    nfa_slot_modulator mod_i (
        .clk     (clk),
        .rst     (rst),
        .active  (busy),
        .sym     (sym),
        .phase   (pos.phase),
        .mod_out (mod_out)
    );

endmodule

// File: rtl/nfa_resp_encoder_chk.sv
module nfa_resp_encoder_chk
    import nfa_enc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic start,
    input logic mod_out,
    input logic busy,
    input logic done
);

    logic [19:0] run_cnt;
    logic [7:0]  hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            run_cnt <= busy ? run_cnt + 20'd1 : '0;
            hi_cnt  <= mod_out ? ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1) : '0;
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3
    slot_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ((int'(run_cnt) % int'(SLOT_CLKS)) == 0 &&
                         int'(run_cnt) >= 3 * int'(SLOT_CLKS)));

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        mod_out |-> (int'(hi_cnt) < int'(SUB_PHASE_CLKS)));

    // R4
    lead_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !mod_out);

    // R8
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !mod_out);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind nfa_resp_encoder nfa_resp_encoder_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mod_out (mod_out),
    .busy    (busy),
    .done    (done)
);

// File: tb/nfa_resp_encoder_tb_top.sv
module nfa_resp_encoder_tb_top;

    localparam int MB = 10;
    localparam int CW = 8;
    localparam int DW = MB * 8;
    localparam int PW = ((MB + 7) / 8) * 8;
    localparam int SLOT = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] frame_data = '0;
    logic [PW-1:0] parity_bits = '0;
    logic [CW-1:0] bit_count = '0;
    logic          mod_out;
    logic          busy;
    logic          done;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    nfa_resp_encoder #(.MAX_BYTES(MB), .CNT_W(CW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .frame_data  (frame_data),
        .parity_bits (parity_bits),
        .bit_count   (bit_count),
        .mod_out     (mod_out),
        .busy        (busy),
        .done        (done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    // Slot codes of the model: 0 silent, 1 first half, 2 second half.
    function automatic void build_slots(ref int q[$], input logic [DW-1:0] d,
                                        input logic [PW-1:0] p, input int n);
        q.delete();
        q.push_back(0);
        q.push_back(1);
        if (n < 8) begin
            for (int i = 0; i < n; i++) q.push_back(d[i] ? 1 : 2);
        end else begin
            int nb;
            nb = n / 8;
            if (nb > MB) nb = MB;
            for (int b = 0; b < nb; b++) begin
                for (int i = 0; i < 8; i++) q.push_back(d[b*8+i] ? 1 : 2);
                q.push_back(p[(b/8)*8 + 7 - (b%8)] ? 1 : 2);
            end
        end
        q.push_back(0);
    endfunction

    function automatic int level(input int s, input int k);
        int ph;
        ph = k / 8;
        if (s == 1 && ph < 8 && ph % 2 == 0) return 1;
        if (s == 2 && ph >= 8 && ph % 2 == 0) return 1;
        return 0;
    endfunction

    // Sends one frame and compares every clock against the model.
    // poke: issue a stray start with altered inputs halfway through (R10).
    task automatic run_frame(input logic [DW-1:0] d, input logic [PW-1:0] p,
                             input int n, input string tag, input bit poke);
        int slots[$];
        int len;
        int prev;
        build_slots(slots, d, p, n);
        len = slots.size() * SLOT;
        @(negedge clk);
        frame_data  = d;
        parity_bits = p;
        bit_count   = CW'(n);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        prev = 0;
        for (int k = 0; k < len; k++) begin
            chk("R2", "busy", int'(busy), 1);
            chk("R9", "done", int'(done), 0);
            chk(tag, "mod_out", int'(mod_out), prev);
            prev = level(slots[k / SLOT], k % SLOT);
            if (poke && k == len / 2) begin
                start       = 1'b1;
                frame_data  = ~d;
                parity_bits = ~p;
                bit_count   = CW'(n + 9);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2", "busy after frame", int'(busy), 0);
        chk("R9", "done pulse", int'(done), 1);
        chk("R8", "mod_out after frame", int'(mod_out), 0);
        @(negedge clk);
        chk("R9", "done cleared", int'(done), 0);
        chk(poke ? "R10" : "R2", "no restart", int'(busy), 0);
        chk("R8", "mod_out idle", int'(mod_out), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 190000) begin
                miscompares++;
                $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cyc, 190000);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "mod_out in reset", int'(mod_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "mod_out after reset", int'(mod_out), 0);

        // R7: short frames of 7, 1 and 0 bits
        run_frame(80'h26, 16'h0, 7, "R7", 1'b0);
        run_frame(80'h1, 16'h0, 1, "R7", 1'b0);
        run_frame(80'hFF, 16'hFFFF, 0, "R7", 1'b0);

        // R5 / R3 / R4: two whole bytes with parity
        run_frame(80'h2093, 16'h8000, 16, "R5", 1'b0);

        // R6: ten bytes, parity spread over two packed bytes, 3 leftover bits (R5)
        run_frame(80'h0F1E_2D3C_4B5A_6978_8796, 16'hA5C0, 83, "R6", 1'b0);

        // R11: count far beyond the buffer
        run_frame(80'hC3A5_0FF0_1234_5678_9ABC, 16'h3C40, 200, "R11", 1'b0);

        // R10: stray start and input changes mid-frame
        run_frame(80'h5AA5C3, 16'h4000, 24, "R10", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule